// File: doc/BRIEF.md
# Quaternary Priority-Ordered Operator Unit

This is a combinational unit for four-valued logic. Each quaternary digit is carried as a 2-bit binary value. A 5-bit selector chooses one of the 24 orderings of the digits 0 to 3. That ordering defines a dominance operator: when two digits are combined, the one that stands earlier in the ordering wins. The first digit of the ordering is its supremum, and the last digit is its infimum.

The unit combines up to four operand digits. A 2-bit mode chooses one of four operations: a plain two-input operation, a three-input cascade, a four-input cascade, or the dual (star) operation. The dual operation uses the reversed ordering, so the later-ranked digit wins.

Used as a gate, one operand carries data and the other carries control. A control at the infimum lets the data through, and a control at the supremum forces the output to the supremum. The unit also reports the supremum and infimum digits of the selected ordering. It raises an error flag for unused selector codes.

Top module: `quad_rank_unit`

## Requirements
- R1: Selector code k (0 to 23) names the k-th permutation of the digits 0,1,2,3 in lexicographic order. Code 0 is 0,1,2,3, code 6 is 1,0,2,3, code 22 is 3,2,0,1 and code 23 is 3,2,1,0. `sup_o` is the first digit of the ordering and `inf_o` is the last.
- R2: With mode 2'b00, `res_o` is whichever of `d0_i`, `d1_i` stands earlier in the selected ordering.
- R3: With mode 2'b01, `res_o` is the operator applied to the two-input result and `d2_i`.
- R4: With mode 2'b10, `res_o` is the operator applied to the three-input result and `d3_i`.
- R5: With mode 2'b11, `res_o` is whichever of `d0_i`, `d1_i` stands later in the selected ordering (dual operation).
- R6: In mode 2'b00, with `d0_i` as data and `d1_i` as control: a control equal to the infimum gives `res_o` = `d0_i`, and a control equal to the supremum gives `res_o` = the supremum.
- R7: With selector code 0 and mode 2'b00, a data digit passes unchanged exactly when it is less than or equal to the control digit; otherwise `res_o` is the control digit. Control 0 passes only 0, and control 3 passes every digit.
- R8: Selector codes 24 to 31 drive `sel_err_o` to 1, and every output then behaves as for code 0. Codes 0 to 23 give `sel_err_o` = 0.
- R9: Code 6 has supremum 1 and infimum 3. Its dual operation (mode 2'b11) gives the same result as mode 2'b00 under code 22 for every operand pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sel_i | input | 5 | Ordering selector, lexicographic permutation index |
| mode_i | input | 2 | 00 pair, 01 three-input cascade, 10 four-input cascade, 11 dual pair |
| d0_i | input | 2 | Operand digit 0 (data in gate use) |
| d1_i | input | 2 | Operand digit 1 (control in gate use) |
| d2_i | input | 2 | Operand digit 2 |
| d3_i | input | 2 | Operand digit 3 |
| res_o | output | 2 | Result digit |
| sup_o | output | 2 | Supremum digit of the selected ordering |
| inf_o | output | 2 | Infimum digit of the selected ordering |
| sel_err_o | output | 1 | Selector code outside 0 to 23 |

## Verification
Two cases are the hardest to reach from the ports. The first is the fallback for the eight unused selector codes, which only shows when the outputs under those codes are compared against code 0. The second is a pair of gate extremes whose control digit differs for each ordering. The stimulus sweeps all 32 selector codes in every mode over all 256 operand combinations. The expected results come from a permutation list the bench builds with nested loops. It then drives each ordering's own infimum and supremum as the control. It also compares the dual of code 6 against the plain operator of code 22, pair by pair.

// File: rtl/quad_rank_pkg.sv
package quad_rank_pkg;
    localparam int RADIX   = 4;
    localparam int DW      = 2;
    localparam int SEL_W   = 5;

    function automatic int fact(input int n);
        int f;
        f = 1;
        for (int i = 2; i <= n; i++) f = f * i;
        return f;
    endfunction

    localparam int NUM_ORD = fact(RADIX);

    typedef logic [DW-1:0] digit_t;
    typedef digit_t [RADIX-1:0] table_t;

    typedef enum logic [1:0] {
        MODE_PAIR   = 2'b00,
        MODE_TRIPLE = 2'b01,
        MODE_QUAD   = 2'b10,
        MODE_DUAL   = 2'b11
    } mode_e;

    // Lexicographic permutation of index idx: position -> digit
    function automatic table_t order_of(input logic [SEL_W-1:0] idx);
        table_t           ord;
        logic [RADIX-1:0] used;
        int               rem;
        int               base;
        int               k;
        int               cnt;
        ord  = '0;
        used = '0;
        rem  = int'(idx);
        for (int p = 0; p < RADIX; p++) begin
            base = fact(RADIX - 1 - p);
            k    = rem / base;
            rem  = rem % base;
            cnt  = 0;
            for (int dg = 0; dg < RADIX; dg++) begin
                if (!used[dg]) begin
                    if (cnt == k) begin
                        ord[p]   = digit_t'(dg);
                        used[dg] = 1'b1;
                    end
                    cnt++;
                end
            end
        end
        return ord;
    endfunction
endpackage

// File: rtl/quad_order_dec.sv
module quad_order_dec
    import quad_rank_pkg::*;
(
    input  logic [SEL_W-1:0] sel_i,
    output table_t           order_o,
    output table_t           rank_o,
    output digit_t           sup_o,
    output digit_t           inf_o,
    output logic             err_o
);
    logic [SEL_W-1:0] eff_sel;

    always_comb begin
        err_o   = (int'(sel_i) >= NUM_ORD);
        eff_sel = err_o ? '0 : sel_i;
        order_o = order_of(eff_sel);
        rank_o  = '0;
        for (int p = 0; p < RADIX; p++) rank_o[order_o[p]] = digit_t'(p);
        sup_o = order_o[0];
        inf_o = order_o[RADIX-1];
    end

    logic [RADIX-1:0] seen;
    always_comb begin
        seen = '0;
        for (int p = 0; p < RADIX; p++) seen[order_o[p]] = 1'b1;
        // R1
        perm_valid_chk: assert ($countones(seen) == RADIX);
        // R8
        if (err_o) begin
            for (int p = 0; p < RADIX; p++)
                fallback_natural_chk: assert (order_o[p] == digit_t'(p));
        end
    end
endmodule

// File: rtl/quad_pick.sv
module quad_pick
    import quad_rank_pkg::*;
#(
    parameter bit STAR = 1'b0
) (
    input  table_t rank_i,
    input  digit_t a_i,
    input  digit_t b_i,
    output digit_t y_o
);
    generate
        if (STAR) begin : g_dual
            always_comb y_o = (rank_i[a_i] >= rank_i[b_i]) ? a_i : b_i;
        end else begin : g_plain
            always_comb y_o = (rank_i[a_i] <= rank_i[b_i]) ? a_i : b_i;
        end
    endgenerate

    always_comb begin
        // R2
        pick_operand_chk: assert (y_o == a_i || y_o == b_i);
        if (!STAR) begin
            // R6
            if (rank_i[b_i] == digit_t'(RADIX-1))
                gate_open_chk: assert (y_o == a_i);
            // R6
            if (rank_i[b_i] == '0)
                gate_closed_chk: assert (y_o == b_i);
        end
    end
endmodule

// File: rtl/quad_rank_unit.sv
module quad_rank_unit
    import quad_rank_pkg::*;
(
    input  logic [SEL_W-1:0] sel_i,
    input  logic [1:0]       mode_i,
    input  logic [DW-1:0]    d0_i,
    input  logic [DW-1:0]    d1_i,
    input  logic [DW-1:0]    d2_i,
    input  logic [DW-1:0]    d3_i,
    output logic [DW-1:0]    res_o,
    output logic [DW-1:0]    sup_o,
    output logic [DW-1:0]    inf_o,
    output logic             sel_err_o
);
    localparam int STAGES = RADIX - 1;

    table_t order;
    table_t rank;
    digit_t operand [RADIX];
    digit_t chain   [RADIX];
    digit_t dual_res;
    mode_e  mode;

    assign operand[0] = d0_i;
    assign operand[1] = d1_i;
    assign operand[2] = d2_i;
    assign operand[3] = d3_i;
    assign chain[0]   = d0_i;
    assign mode       = mode_e'(mode_i);

    quad_order_dec u_dec (
        .sel_i   (sel_i),
        .order_o (order),
        .rank_o  (rank),
        .sup_o   (sup_o),
        .inf_o   (inf_o),
        .err_o   (sel_err_o)
    );

    genvar gi;
    generate
        for (gi = 1; gi <= STAGES; gi++) begin : g_cascade
            quad_pick #(.STAR(1'b0)) u_stage (
                .rank_i (rank),
                .a_i    (chain[gi-1]),
                .b_i    (operand[gi]),
                .y_o    (chain[gi])
            );
        end
    endgenerate

    quad_pick #(.STAR(1'b1)) u_dual (
        .rank_i (rank),
        .a_i    (d0_i),
        .b_i    (d1_i),
        .y_o    (dual_res)
    );

    always_comb begin
        unique case (mode)
            MODE_PAIR:   res_o = chain[1];
            MODE_TRIPLE: res_o = chain[2];
            MODE_QUAD:   res_o = chain[3];
            MODE_DUAL:   res_o = dual_res;
            default:     res_o = chain[1];
        endcase
    end

    logic unused_order;
    assign unused_order = ^order;

    always_comb begin
        // R5
        if (d0_i != d1_i)
            dual_differs_chk: assert (dual_res != chain[1]);
        // R5
        dual_pair_chk: assert ((dual_res == d0_i && chain[1] == d1_i) ||
                               (dual_res == d1_i && chain[1] == d0_i));
        // R4
        cascade_rank_chk: assert (rank[chain[3]] <= rank[chain[2]] &&
                                  rank[chain[2]] <= rank[chain[1]]);
    end
endmodule

// File: tb/sim_quad_rank_unit.sv
module sim_quad_rank_unit;
    logic       clk = 1'b0;
    logic [4:0] sel;
    logic [1:0] mode;
    logic [1:0] d0, d1, d2, d3;
    logic [1:0] res, sup, inf;
    logic       err;
    int         checks = 0;
    int         errors = 0;
    int         ord_ref  [24][4];
    int         rank_ref [4];

    always #5 clk = ~clk;

    quad_rank_unit u0 (
        .sel_i(sel), .mode_i(mode), .d0_i(d0), .d1_i(d1), .d2_i(d2), .d3_i(d3),
        .res_o(res), .sup_o(sup), .inf_o(inf), .sel_err_o(err)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s sel=%0d mode=%0d d=%0d%0d%0d%0d actual=%0d expected=%0d",
                     tag, sel, mode, d0, d1, d2, d3, act, exp);
        end
    endtask

    task automatic apply(input int s, input int m, input int a, input int b,
                         input int c, input int d);
        @(negedge clk);
        sel  = 5'(s);
        mode = 2'(m);
        d0 = 2'(a); d1 = 2'(b); d2 = 2'(c); d3 = 2'(d);
        #2;
    endtask

    function automatic int pk(input int a, input int b, input bit star);
        if (!star) return (rank_ref[a] <= rank_ref[b]) ? a : b;
        return (rank_ref[a] >= rank_ref[b]) ? a : b;
    endfunction

    task automatic set_rank(input int s);
        int e;
        e = (s < 24) ? s : 0;
        for (int p = 0; p < 4; p++) rank_ref[ord_ref[e][p]] = p;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int idx;
        int e;
        int p0;
        int exp;
        int r22;
        idx = 0;
        for (int a = 0; a < 4; a++)
            for (int b = 0; b < 4; b++)
                for (int c = 0; c < 4; c++)
                    for (int d = 0; d < 4; d++)
                        if (a != b && a != c && a != d && b != c && b != d && c != d) begin
                            ord_ref[idx][0] = a; ord_ref[idx][1] = b;
                            ord_ref[idx][2] = c; ord_ref[idx][3] = d;
                            idx++;
                        end

        // Idle state with all inputs low
        apply(0, 0, 0, 0, 0, 0);
        check("R2 idle res", int'(res), 0);
        check("R8 idle err", int'(err), 0);

        // R1 anchor codes
        apply(6, 0, 0, 0, 0, 0);
        check("R1 code6 sup", int'(sup), 1);
        check("R9 code6 inf", int'(inf), 3);
        apply(23, 0, 0, 0, 0, 0);
        check("R1 code23 sup", int'(sup), 3);
        check("R1 code23 inf", int'(inf), 0);

        // Exhaustive sweep: R1 R2 R3 R4 R5 R8
        for (int s = 0; s < 32; s++) begin
            e = (s < 24) ? s : 0;
            set_rank(s);
            for (int m = 0; m < 4; m++) begin
                for (int v = 0; v < 256; v++) begin
                    apply(s, m, v & 3, (v >> 2) & 3, (v >> 4) & 3, (v >> 6) & 3);
                    p0 = pk(int'(d0), int'(d1), 1'b0);
                    case (m)
                        0: begin exp = p0; check("R2 pair", int'(res), exp); end
                        1: begin exp = pk(p0, int'(d2), 1'b0); check("R3 triple", int'(res), exp); end
                        2: begin exp = pk(pk(p0, int'(d2), 1'b0), int'(d3), 1'b0); check("R4 quad", int'(res), exp); end
                        default: begin exp = pk(int'(d0), int'(d1), 1'b1); check("R5 dual", int'(res), exp); end
                    endcase
                    if (v == 0) begin
                        check("R1 sup", int'(sup), ord_ref[e][0]);
                        check("R1 inf", int'(inf), ord_ref[e][3]);
                        check("R8 err flag", int'(err), (s >= 24) ? 1 : 0);
                    end
                end
            end
        end

        // R6 gate extremes per ordering
        for (int s = 0; s < 24; s++) begin
            for (int a = 0; a < 4; a++) begin
                apply(s, 0, a, ord_ref[s][3], 0, 0);
                check("R6 open", int'(res), a);
                apply(s, 0, a, ord_ref[s][0], 0, 0);
                check("R6 closed", int'(res), ord_ref[s][0]);
            end
        end

        // R7 filter under the natural ordering
        for (int c = 0; c < 4; c++)
            for (int a = 0; a < 4; a++) begin
                apply(0, 0, a, c, 0, 0);
                check("R7 filter", int'(res), (a <= c) ? a : c);
            end

        // R9 dual of code 6 equals plain operator of code 22
        for (int a = 0; a < 4; a++)
            for (int b = 0; b < 4; b++) begin
                apply(22, 0, a, b, 0, 0);
                r22 = int'(res);
                apply(6, 3, a, b, 0, 0);
                check("R9 dual match", int'(res), r22);
            end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule